// File: doc/BRIEF.md
# Transmit Descriptor Write-Back Coalescer

This block sits between a transmit engine that retires descriptors and the bus logic that writes completed descriptors back to host memory. Each retired descriptor arrives as a one-cycle completion event with a flag that asks for its status to be reported. The block keeps a count of retired descriptors that have not yet been written back. It decides when that batch is flushed. A flush appears as a request with a descriptor count, held until the bus side acknowledges it. Some flushes also raise a one-cycle write-back interrupt event.

There are two operating styles. In the reset configuration, with bursting off or a zero threshold, a report-flagged completion flushes everything pending at once. With bursting on and a nonzero threshold, descriptors are batched. A batch is flushed when it reaches the threshold, or when a delay countdown runs out. The countdown is measured in prescaled ticks. It is armed by the first completion after an idle period, and later completions do not re-arm it. A reload value of zero turns the countdown off. While a request waits for its acknowledge, new completions build up the next batch. Any trigger seen during that wait is honoured as soon as the bus side is free.

Top module: `txwb_coalescer`

## Requirements
- R1: After reset, wbReq and wbIrq are low and no descriptor is pending.
- R2: In immediate mode (cfgBurstEn low, or cfgThresh zero), a completion with doneReport high raises wbReq in the following cycle. wbCount then equals all pending descriptors including that one, and wbIrq pulses in the same cycle as the request rises.
- R3: In immediate mode, completions with doneReport low are counted but raise no request.
- R4: In burst mode (cfgBurstEn high and cfgThresh nonzero), when the pending count including the current completion reaches cfgThresh, a request with wbCount equal to cfgThresh rises the next cycle, with no wbIrq.
- R5: In burst mode with nonzero cfgDelay, the first completion after idle loads the countdown. Later completions do not reload it. On the cfgDelay-th tick after loading, all pending descriptors, including one completing in that cycle, are flushed, and wbIrq pulses.
- R6: With cfgDelay zero in burst mode, ticks never cause a flush.
- R7: A flush empties the pending count and stops the countdown. The next completion starts a fresh batch and a fresh countdown.
- R8: While a request awaits wbAck, completions keep accumulating. In the acknowledge cycle, a pending trigger issues the next request, and its count covers exactly the descriptors that arrived since the previous flush.
- R9: When the threshold is reached and the countdown expires in the same cycle, exactly one request and one wbIrq pulse result.
- R10: wbReq stays high with a stable wbCount until a cycle with wbAck high. It then drops unless another flush issues in that cycle.
- R11: In burst mode, doneReport has no effect on when a flush happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBurstEn | input | 1 | Enables batching and delayed flushing |
| cfgThresh | input | CNT_W | Batch size for a threshold flush; zero selects immediate mode |
| cfgDelay | input | TMR_W | Countdown reload in ticks; zero disables timed flushing |
| doneValid | input | 1 | One descriptor completed this cycle |
| doneReport | input | 1 | The completed descriptor asks for status reporting |
| tick | input | 1 | Prescaled time base for the countdown |
| wbReq | output | 1 | Write-back request, held until acknowledged |
| wbCount | output | CNT_W | Number of descriptors to write back |
| wbAck | input | 1 | Bus side accepts the current request |
| wbIrq | output | 1 | One-cycle write-back interrupt event |

## Verification
The hardest case to reach is the one where several triggers arrive together and the bus is busy. In one case, the countdown's last tick falls on the very completion that fills the threshold. In another, completions pile up behind an unacknowledged request. The bench reaches the coincidence by choosing the threshold as one plus the countdown reload. It then sends a completion on every tick, so both conditions line up by arithmetic. It reaches the backlog by holding wbAck low across extra completions, then checks the count that is issued in the acknowledge cycle.

// File: rtl/txwb_pkg.sv
package txwb_pkg;
  typedef struct packed {
    logic issue;      // start a write-back of the current sum
    logic loadTimer;  // arm the countdown with the reload value
    logic decTimer;   // consume one tick
  } wbStrobe_t;
endpackage

// File: rtl/txwb_datapath.sv
module txwb_datapath
  import txwb_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             doneValid,
  input  logic [CNT_W-1:0] cfgThresh,
  input  logic [TMR_W-1:0] cfgDelay,
  input  wbStrobe_t        strobe,
  output logic             thrHit,
  output logic             timerLast,
  output logic             sumNonZero,
  output logic [CNT_W-1:0] wbCount
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);

  logic [CNT_W-1:0] pendingQ;
  logic [CNT_W-1:0] sum;
  logic [TMR_W-1:0] timerQ;

  // pending count including the descriptor retiring this cycle
  always_comb begin
    sum        = doneValid ? pendingQ + CNT_ONE : pendingQ;
    sumNonZero = (sum != '0);
    thrHit     = (cfgThresh != '0) && (sum >= cfgThresh);
    timerLast  = (timerQ == TMR_ONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= '0;
      wbCount  <= '0;
      timerQ   <= '0;
    end else begin
      if (strobe.issue) begin
        wbCount  <= sum;
        pendingQ <= '0;
      end else begin
        pendingQ <= sum;
      end
      if (strobe.loadTimer)     timerQ <= cfgDelay;
      else if (strobe.decTimer) timerQ <= timerQ - TMR_ONE;
    end
  end
endmodule

// File: rtl/txwb_ctrl.sv
module txwb_ctrl
  import txwb_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgBurstEn,
  input  logic [CNT_W-1:0] cfgThresh,
  input  logic [TMR_W-1:0] cfgDelay,
  input  logic             doneValid,
  input  logic             doneReport,
  input  logic             tick,
  input  logic             wbAck,
  input  logic             thrHit,
  input  logic             timerLast,
  input  logic             sumNonZero,
  output wbStrobe_t        strobe,
  output logic             wbReq,
  output logic             wbIrq
);
  logic burstMode, timerOn, busy;
  logic rsNow, expireNow, want, irqCause;
  logic running, expFlag, rsFlag;

  always_comb begin
    burstMode = cfgBurstEn && (cfgThresh != '0);
    timerOn   = burstMode && (cfgDelay != '0);
    busy      = wbReq && !wbAck;
    rsNow     = !burstMode && doneValid && doneReport;
    expireNow = running && tick && timerLast;
    irqCause  = rsFlag || rsNow || expFlag || expireNow;
    want      = irqCause || (burstMode && thrHit);
    strobe.issue     = want && !busy && sumNonZero;
    strobe.decTimer  = running && tick;
    strobe.loadTimer = timerOn && !running && !expFlag && doneValid && !strobe.issue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      expFlag <= 1'b0;
      rsFlag  <= 1'b0;
      wbReq   <= 1'b0;
      wbIrq   <= 1'b0;
    end else begin
      wbIrq <= strobe.issue && irqCause;
      if (strobe.issue) begin
        running <= 1'b0;
        expFlag <= 1'b0;
        rsFlag  <= 1'b0;
        wbReq   <= 1'b1;
      end else begin
        if (expireNow)             running <= 1'b0;
        else if (strobe.loadTimer) running <= 1'b1;
        if (expireNow) expFlag <= 1'b1;
        if (rsNow)     rsFlag  <= 1'b1;
        if (wbAck)     wbReq   <= 1'b0;
      end
    end
  end

  // R2: a report-flagged completion in immediate mode flushes at once when free
  assert_imm_flush_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rsNow && !busy) |=> (wbReq && wbIrq));

  // R10: an unacknowledged request is held
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> wbReq);

  // R9: every interrupt pulse accompanies a freshly issued request
  assert_irq_with_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbIrq |-> wbReq);

  // R5: an expired countdown is never running at the same time
  assert_timer_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(running && expFlag));
endmodule

// File: rtl/txwb_coalescer.sv
module txwb_coalescer
  import txwb_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgBurstEn,
  input  logic [CNT_W-1:0] cfgThresh,
  input  logic [TMR_W-1:0] cfgDelay,
  input  logic             doneValid,
  input  logic             doneReport,
  input  logic             tick,
  output logic             wbReq,
  output logic [CNT_W-1:0] wbCount,
  input  logic             wbAck,
  output logic             wbIrq
);
  wbStrobe_t strobe;
  logic thrHit, timerLast, sumNonZero;

  txwb_ctrl #(.CNT_W(CNT_W), .TMR_W(TMR_W)) ctrl (
    .clk(clk), .rstN(rstN), .cfgBurstEn(cfgBurstEn), .cfgThresh(cfgThresh),
    .cfgDelay(cfgDelay), .doneValid(doneValid), .doneReport(doneReport),
    .tick(tick), .wbAck(wbAck), .thrHit(thrHit), .timerLast(timerLast),
    .sumNonZero(sumNonZero), .strobe(strobe), .wbReq(wbReq), .wbIrq(wbIrq)
  );

  txwb_datapath #(.CNT_W(CNT_W), .TMR_W(TMR_W)) dp (
    .clk(clk), .rstN(rstN), .doneValid(doneValid), .cfgThresh(cfgThresh),
    .cfgDelay(cfgDelay), .strobe(strobe), .thrHit(thrHit),
    .timerLast(timerLast), .sumNonZero(sumNonZero), .wbCount(wbCount)
  );

  // R10: the count presented with a waiting request does not move
  assert_count_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq && !wbAck) |=> $stable(wbCount));

  // R8: a request never carries an empty batch
  assert_count_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> (wbCount != '0));
endmodule

// File: tb/txwb_coalescer_test.sv
module txwb_coalescer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;
  localparam int TMR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgBurstEn = 1'b0;
  logic [CNT_W-1:0] cfgThresh = '0;
  logic [TMR_W-1:0] cfgDelay = '0;
  logic doneValid = 1'b0, doneReport = 1'b0, tick = 1'b0, wbAck = 1'b0;
  logic wbReq, wbIrq;
  logic [CNT_W-1:0] wbCount;

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txwb_coalescer #(.CNT_W(CNT_W), .TMR_W(TMR_W)) uut (
    .clk(clk), .rstN(rstN), .cfgBurstEn(cfgBurstEn), .cfgThresh(cfgThresh),
    .cfgDelay(cfgDelay), .doneValid(doneValid), .doneReport(doneReport),
    .tick(tick), .wbReq(wbReq), .wbCount(wbCount), .wbAck(wbAck), .wbIrq(wbIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, observe just after the rising edge
  task automatic step(input logic v, input logic rs, input logic tk, input logic ak);
    @(negedge clk);
    doneValid = v; doneReport = rs; tick = tk; wbAck = ak;
    @(posedge clk);
    #1;
    doneValid = 1'b0; doneReport = 1'b0; tick = 1'b0; wbAck = 1'b0;
  endtask

  task automatic drain(input string tag);
    step(0, 0, 0, 1);
    check(tag, int'(wbReq), 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1: quiet after reset
    check("R1 wbReq", int'(wbReq), 0);
    check("R1 wbIrq", int'(wbIrq), 0);

    // R2/R3 immediate mode, both ways of selecting it
    for (int m = 0; m < 2; m++) begin
      cfgBurstEn = (m == 1);
      cfgThresh  = '0;
      cfgDelay   = 8'd3;
      for (int n = 0; n <= 4; n++) begin
        for (int i = 0; i < n; i++) begin
          step(1, 0, 1, 0);
          check("R3 no request", int'(wbReq), 0);
        end
        step(1, 1, 0, 0);
        check("R2 request", int'(wbReq), 1);
        check("R2 count", int'(wbCount), n + 1);
        check("R2 irq", int'(wbIrq), 1);
        step(0, 0, 0, 0);
        check("R10 held", int'(wbReq), 1);
        check("R10 count stable", int'(wbCount), n + 1);
        check("R2 irq single pulse", int'(wbIrq), 0);
        drain("R10 drop on ack");
      end
    end

    // R4/R11 threshold batching, report flag set on every descriptor
    cfgBurstEn = 1'b1;
    cfgDelay   = '0;
    for (int t = 1; t <= 5; t++) begin
      cfgThresh = CNT_W'(t);
      for (int i = 1; i < t; i++) begin
        step(1, 1, 0, 0);
        check("R11 report ignored", int'(wbReq), 0);
      end
      step(1, 1, 0, 0);
      check("R4 request", int'(wbReq), 1);
      check("R4 count", int'(wbCount), t);
      check("R4 no irq", int'(wbIrq), 0);
      drain("R4 drain");
    end

    // R5/R7 countdown flush, large threshold so only the timer fires
    cfgThresh = 6'd40;
    for (int d = 1; d <= 4; d++) begin
      cfgDelay = TMR_W'(d);
      step(1, 0, 0, 0);
      for (int k = 1; k <= d; k++) begin
        step(0, 0, 0, 0);
        step(1, 0, 1, 0);
        if (k < d) check("R5 no early flush", int'(wbReq), 0);
      end
      check("R5 timer request", int'(wbReq), 1);
      check("R5 count", int'(wbCount), d + 1);
      check("R5 irq", int'(wbIrq), 1);
      drain("R5 drain");
      // R7: fresh batch and fresh countdown
      step(1, 0, 0, 0);
      for (int k = 1; k <= d; k++) begin
        step(0, 0, 1, 0);
        if (k < d) check("R7 no early flush", int'(wbReq), 0);
      end
      check("R7 request", int'(wbReq), 1);
      check("R7 count", int'(wbCount), 1);
      drain("R7 drain");
    end

    // R6: zero reload, ticks never flush
    cfgDelay = '0;
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    for (int i = 0; i < 10; i++) begin
      step(0, 0, 1, 0);
      check("R6 no timer flush", int'(wbReq), 0);
    end
    cfgBurstEn = 1'b0;
    step(1, 1, 0, 0);
    check("R6 backlog kept", int'(wbCount), 4);
    drain("R6 drain");

    // R8: backlog behind an unacknowledged request
    cfgBurstEn = 1'b1;
    cfgThresh  = 6'd2;
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    check("R8 first request", int'(wbCount), 2);
    for (int i = 0; i < 3; i++) begin
      step(1, 0, 0, 0);
      check("R8 held while busy", int'(wbReq), 1);
      check("R8 count unchanged", int'(wbCount), 2);
    end
    step(0, 0, 0, 1);
    check("R8 reissue in ack cycle", int'(wbReq), 1);
    check("R8 backlog count", int'(wbCount), 3);
    drain("R8 drain");

    // R9: threshold and expiry coincide, threshold = reload + 1
    for (int d = 1; d <= 3; d++) begin
      cfgDelay  = TMR_W'(d);
      cfgThresh = CNT_W'(d + 1);
      step(1, 0, 0, 0);
      for (int k = 1; k <= d; k++) step(1, 0, 1, 0);
      check("R9 request", int'(wbReq), 1);
      check("R9 count", int'(wbCount), d + 1);
      check("R9 irq", int'(wbIrq), 1);
      step(0, 0, 0, 0);
      check("R9 single irq", int'(wbIrq), 0);
      drain("R9 single request");
      step(0, 0, 1, 0);
      check("R9 nothing left", int'(wbReq), 0);
    end

    summary();
  end
endmodule